// File: doc/BRIEF.md
# Recursive Phasor Quadrature Down-Mixer

This block moves a real-valued sample stream to baseband as in-phase and quadrature samples. Each accepted input sample is multiplied by a complex local oscillator. The oscillator is a phasor that starts at exactly 1+0j. After every accepted sample it is rotated by one multiplication with a programmable complex step. No sine table or phase accumulator is involved.

Software or a control block tunes the mixer by writing the step. For a tuning angle w per sample the step is cos(w) - j·sin(w). A write also puts the phasor back to 1+0j, so every retune starts from a known phase. Rounding makes the phasor magnitude drift a little on each rotation. At a fixed interval the rotation result is therefore scaled by a first-order correction (3 - |p|²)/2, which pulls the magnitude back towards one.

The mixed products come out as signed I and Q samples with a valid strobe, three register stages after the input. Any filtering or decimation is left to blocks further down the chain.

Top module: `rot_mixer`

## Requirements
- R1: After reset `out_valid` is 0, `out_i` and `out_q` are 0, the phasor is 1+0j and the step is 1+0j. Until the first step write, each sample x therefore gives I = x and Q = 0.
- R2: Each sample presented with `in_valid` high at a rising edge gives exactly one `out_valid` pulse. That pulse is visible after the third rising edge, counting the accepting edge as the first. `out_valid` is low in all other cycles.
- R3: For sample x and the phasor p held when x is accepted, `out_i` = (x·Re(p) + 2^15) >>> 16 and `out_q` = (x·Im(p) + 2^15) >>> 16. The results are 16-bit signed and never saturate.
- R4: Phasor and step are 18-bit signed values with 16 fraction bits, so 1.0 = 65536. After each accepted sample (without a step write in that cycle) the phasor becomes the complex product p·s. Each part of the product is rounded as (v + 2^15) >>> 16. In a cycle with no accepted sample and no step write, the phasor is unchanged.
- R5: A write (`step_wr` high at an edge) loads `step_re` and `step_im`, sets the phasor to 1+0j and clears the correction interval. A sample accepted in the same cycle is mixed with the phasor held before the write.
- R6: On the 16th accepted sample after reset or a step write, and on every 16th one after that, the rotated phasor q is replaced as follows. First k = (3·2^32 - (Re(q)² + Im(q)²)) >>> 17 is formed. Then each part of q becomes q·k, rounded as in R4.
- R7: Every rounded phasor part is saturated to the range -131072 to 131071.
- R8: Between output pulses, `out_i` and `out_q` keep the values of the last pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_wr | input | 1 | Load the step and restart the phasor at 1+0j |
| step_re | input | 18 | Real part of the rotation step, 16 fraction bits |
| step_im | input | 18 | Imaginary part of the rotation step, 16 fraction bits |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 14 | Signed real input sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
The magnitude correction is the hardest behaviour to reach from the ports. With a unit-magnitude step the correction factor rounds to exactly one, and it has no visible effect. The stimulus therefore loads steps whose magnitude is clearly above one. One is slightly above one, so the growth and pull-back show up in the outputs. The other is large enough to drive the phasor into saturation, so the correction factor turns negative. Both runs go past several 16-sample intervals, and the bench follows them with its own integer model. A step write arrives in the same cycle as a valid sample, which exercises the ordering between retune and advance.

// File: rtl/mix_pkg.sv
// Package: shared defaults and fixed-point helpers for the down-mixer.
// Assumes phasor and step words carry two integer bits (sign plus one).
package mix_pkg;
    localparam int SAMP_W_DEF = 14;
    localparam int PH_W_DEF   = 18;
    localparam int PERIOD_DEF = 16;

    // Fraction bits of a phasor word of the given width.
    function automatic int frac_of(input int ph_w);
        return ph_w - 2;
    endfunction
endpackage

// File: rtl/osc_phasor.sv
// Module: recursive complex oscillator. Holds the step and the current
// phasor. Rotates the phasor by the step on every advance and applies a
// first-order magnitude correction every PERIOD advances.
// Assumes PERIOD >= 2 and that step writes take priority over advances.
module osc_phasor #(
    parameter int PH_W   = mix_pkg::PH_W_DEF,
    parameter int PERIOD = mix_pkg::PERIOD_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_wr,
    input  logic signed [PH_W-1:0] step_re,
    input  logic signed [PH_W-1:0] step_im,
    input  logic                   adv,
    output logic signed [PH_W-1:0] ph_re,
    output logic signed [PH_W-1:0] ph_im
);
    localparam int FRAC  = mix_pkg::frac_of(PH_W);
    localparam int ACC_W = 2 * PH_W + 1;
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic signed [PH_W-1:0]  ONE   = PH_W'(1 << FRAC);
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] PMAX  = ACC_W'((1 << (PH_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] PMIN  = ~PMAX;
    localparam logic signed [ACC_W-1:0] THREE = ACC_W'(3) << (2 * FRAC);

    logic signed [PH_W-1:0]  s_re, s_im, p_re, p_im;
    logic        [CNT_W-1:0] cnt;
    logic signed [ACC_W-1:0] wp_re, wp_im, ws_re, ws_im, wq_re, wq_im;
    logic signed [ACC_W-1:0] mag2, kfac;
    logic signed [PH_W-1:0]  q_re, q_im, n_re, n_im;
    logic                    do_norm;

    // Round half up by FRAC bits, then clamp to the phasor range.
    function automatic logic signed [PH_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + HALF) >>> FRAC;
        if (r > PMAX)      rnd_sat = PMAX[PH_W-1:0];
        else if (r < PMIN) rnd_sat = PMIN[PH_W-1:0];
        else               rnd_sat = r[PH_W-1:0];
    endfunction

    // Rotation by the step, then the magnitude correction candidate.
    always_comb begin
        wp_re   = ACC_W'(p_re);
        wp_im   = ACC_W'(p_im);
        ws_re   = ACC_W'(s_re);
        ws_im   = ACC_W'(s_im);
        q_re    = rnd_sat(wp_re * ws_re - wp_im * ws_im);
        q_im    = rnd_sat(wp_re * ws_im + wp_im * ws_re);
        wq_re   = ACC_W'(q_re);
        wq_im   = ACC_W'(q_im);
        mag2    = wq_re * wq_re + wq_im * wq_im;
        kfac    = (THREE - mag2) >>> (FRAC + 1);
        n_re    = rnd_sat(wq_re * kfac);
        n_im    = rnd_sat(wq_im * kfac);
        do_norm = (cnt == CNT_W'(PERIOD - 1));
    end

    // Step, phasor and correction-interval registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_re <= ONE;
            s_im <= '0;
            p_re <= ONE;
            p_im <= '0;
            cnt  <= '0;
        end else if (step_wr) begin
            s_re <= step_re;
            s_im <= step_im;
            p_re <= ONE;
            p_im <= '0;
            cnt  <= '0;
        end else if (adv) begin
            p_re <= do_norm ? n_re : q_re;
            p_im <= do_norm ? n_im : q_im;
            cnt  <= do_norm ? '0 : cnt + CNT_W'(1);
        end
    end

    assign ph_re = p_re;
    assign ph_im = p_im;
endmodule

// File: rtl/mix_mult.sv
// Module: three-stage real-by-complex multiplier. Captures the sample and
// phasor, forms both products, then rounds them to the output width.
// Assumes OUT_W is at least SAMP_W + 2 so that no result can overflow.
module mix_mult #(
    parameter int SAMP_W = mix_pkg::SAMP_W_DEF,
    parameter int PH_W   = mix_pkg::PH_W_DEF,
    parameter int OUT_W  = SAMP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_sample,
    input  logic signed [PH_W-1:0]   ph_re,
    input  logic signed [PH_W-1:0]   ph_im,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);
    localparam int FRAC = mix_pkg::frac_of(PH_W);
    localparam int PR_W = SAMP_W + PH_W;
    localparam logic signed [PR_W-1:0] HALF = PR_W'(1) << (FRAC - 1);

    logic                     v1, v2;
    logic signed [SAMP_W-1:0] x1;
    logic signed [PH_W-1:0]   ph [2];
    logic signed [PH_W-1:0]   c1 [2];
    logic signed [PR_W-1:0]   prod [2];
    logic signed [PR_W-1:0]   rnd [2];
    logic signed [OUT_W-1:0]  rail [2];

    assign ph[0] = ph_re;
    assign ph[1] = ph_im;

    // Valid strobe and sample capture shared by both rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            v2        <= 1'b0;
            out_valid <= 1'b0;
            x1        <= '0;
        end else begin
            v1        <= in_valid;
            v2        <= v1;
            out_valid <= v2;
            if (in_valid) x1 <= in_sample;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_rail
        // Rounded view of this rail's product.
        assign rnd[g] = (prod[g] + HALF) >>> FRAC;

        // Capture, multiply and round for one output rail.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c1[g]   <= '0;
                prod[g] <= '0;
                rail[g] <= '0;
            end else begin
                if (in_valid) c1[g]   <= ph[g];
                if (v1)       prod[g] <= PR_W'(x1) * PR_W'(c1[g]);
                if (v2)       rail[g] <= rnd[g][OUT_W-1:0];
            end
        end
    end

    assign out_i = rail[0];
    assign out_q = rail[1];
endmodule

// File: rtl/rot_mixer.sv
// Module: top of the quadrature down-mixer. Joins the recursive oscillator
// to the mixing pipeline. Every accepted sample advances the phasor.
// Assumes a synchronous active-low reset and one sample per clock at most.
module rot_mixer #(
    parameter int SAMP_W = mix_pkg::SAMP_W_DEF,
    parameter int PH_W   = mix_pkg::PH_W_DEF,
    parameter int PERIOD = mix_pkg::PERIOD_DEF,
    parameter int OUT_W  = SAMP_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_wr,
    input  logic signed [PH_W-1:0]   step_re,
    input  logic signed [PH_W-1:0]   step_im,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_sample,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_i,
    output logic signed [OUT_W-1:0]  out_q
);
    logic signed [PH_W-1:0] ph_re, ph_im;

    osc_phasor #(.PH_W(PH_W), .PERIOD(PERIOD)) u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_wr (step_wr),
        .step_re (step_re),
        .step_im (step_im),
        .adv     (in_valid),
        .ph_re   (ph_re),
        .ph_im   (ph_im)
    );

    mix_mult #(.SAMP_W(SAMP_W), .PH_W(PH_W), .OUT_W(OUT_W)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .ph_re     (ph_re),
        .ph_im     (ph_im),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );
endmodule

// File: rtl/mixer_chk.sv
// Module: property checker bound to rot_mixer. Watches the strobe latency,
// the retune restart and the hold behaviour of phasor and outputs.
module mixer_chk #(
    parameter int PH_W  = 18,
    parameter int OUT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   step_wr,
    input logic signed [PH_W-1:0] ph_re,
    input logic signed [PH_W-1:0] ph_im,
    input logic                   out_valid,
    input logic [OUT_W-1:0]       out_i,
    input logic [OUT_W-1:0]       out_q
);
    localparam logic signed [PH_W-1:0] ONE = PH_W'(1 << (PH_W - 2));

    logic [2:0] vd;

    // Independent record of recent input strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) vd <= '0;
        else        vd <= {vd[1:0], in_valid};
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vd[2]); // R2

    AST_RETUNE_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        step_wr |=> (ph_re == ONE && ph_im == '0)); // R5

    AST_PHASOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !step_wr) |=> ($stable(ph_re) && $stable(ph_im))); // R4

    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q))); // R8
endmodule

bind rot_mixer mixer_chk #(.PH_W(PH_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .step_wr   (step_wr),
    .ph_re     (ph_re),
    .ph_im     (ph_im),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_rot_mixer.sv
// Bench: integer reference model of the mixer, compared on every clock.
module sim_rot_mixer;
    localparam int SAMP_W = 14;
    localparam int PH_W   = 18;
    localparam int OUT_W  = 16;
    localparam int PERIOD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_wr = 1'b0;
    logic signed [PH_W-1:0] step_re = '0, step_im = '0;
    logic in_valid = 1'b0;
    logic signed [SAMP_W-1:0] in_sample = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_i, out_q;

    always #10 clk = ~clk;

    rot_mixer #(.SAMP_W(SAMP_W), .PH_W(PH_W), .PERIOD(PERIOD), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .step_wr(step_wr), .step_re(step_re),
        .step_im(step_im), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    typedef struct { int due; longint i; longint q; } exp_t;
    exp_t expq[$];
    int checks = 0, errors = 0, cyc = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";
    longint mp_re = 65536, mp_im = 0, ms_re = 65536, ms_im = 0;
    longint last_i = 0, last_q = 0;
    int mcnt = 0;

    function automatic longint rnd(input longint v);
        return (v + 32768) >>> 16;
    endfunction

    function automatic longint sat(input longint v);
        if (v > 131071) return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    // Model phasor advance: rotation, then correction every PERIOD advances (R4, R6, R7).
    task automatic model_advance();
        longint qr, qi, m, k;
        qr = sat(rnd(mp_re * ms_re - mp_im * ms_im));
        qi = sat(rnd(mp_re * ms_im + mp_im * ms_re));
        mcnt++;
        if (mcnt == PERIOD) begin
            m  = qr * qr + qi * qi;
            k  = ((longint'(3) <<< 32) - m) >>> 17;
            qr = sat(rnd(qr * k));
            qi = sat(rnd(qi * k));
            mcnt = 0;
        end
        mp_re = qr;
        mp_im = qi;
    endtask

    // One clock: drive inputs, then update the model after the edge.
    task automatic drive(input bit wr, input longint sre, input longint sim,
                         input bit vld, input int x);
        exp_t e;
        @(negedge clk);
        step_wr   = wr;
        step_re   = sre[PH_W-1:0];
        step_im   = sim[PH_W-1:0];
        in_valid  = vld;
        in_sample = x[SAMP_W-1:0];
        @(posedge clk);
        cyc++;
        if (vld) begin
            e.due = cyc + 2;
            e.i   = rnd(longint'(x) * mp_re);
            e.q   = rnd(longint'(x) * mp_im);
            expq.push_back(e);
        end
        if (wr) begin
            ms_re = sre; ms_im = sim; mp_re = 65536; mp_im = 0; mcnt = 0;
        end else if (vld) begin
            model_advance();
        end
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) drive(1'b0, 0, 0, 1'b0, 0);
    endtask

    // Per-cycle comparison of strobe and data against the model (R2, R3, R8).
    always @(negedge clk) begin
        if (chk_on) begin
            bit ev;
            ev = (expq.size() > 0) && (expq[0].due == cyc);
            if (ev) begin
                last_i = expq[0].i;
                last_q = expq[0].q;
                void'(expq.pop_front());
            end
            checks++;
            if (out_valid !== ev || longint'(out_i) != last_i || longint'(out_q) != last_q) begin
                errors++;
                $display("FAIL %s: cycle %0d valid/i/q = %0d/%0d/%0d expected %0d/%0d/%0d",
                         cur_req, cyc, out_valid, out_i, out_q, ev, last_i, last_q);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || out_i !== '0 || out_q !== '0) begin
            errors++;
            $display("FAIL R1: reset outputs %0d/%0d/%0d expected 0/0/0", out_valid, out_i, out_q);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: unity phasor and step pass the sample through on I
        cur_req = "R1";
        drive(0, 0, 0, 1, 100);
        drive(0, 0, 0, 1, -200);
        drive(0, 0, 0, 1, 8191);
        drive(0, 0, 0, 1, -8192);
        idle(4);

        // R4: quarter-turn step (0 - 1j) cycles the phasor exactly
        cur_req = "R4";
        drive(1, 0, -65536, 0, 0);
        for (int j = 0; j < 12; j++) drive(0, 0, 0, 1, 1000 + 37 * j);
        idle(4);

        // R3: tuning at one sixteenth of a turn with several sample patterns
        cur_req = "R3";
        drive(1, 60547, -25080, 0, 0);
        for (int j = 0; j < 20; j++) drive(0, 0, 0, 1, 4000);
        for (int j = 0; j < 20; j++) drive(0, 0, 0, 1, (j % 2) ? -8192 : 8191);
        for (int j = 0; j < 20; j++) drive(0, 0, 0, 1, (j * 911) % 8192 - 4096);
        idle(4);

        // R2 and R8: sparse strobes, outputs hold between pulses
        cur_req = "R8";
        x = 7;
        for (int j = 0; j < 60; j++) begin
            x = (x * 1103 + 17) % 8191;
            drive(0, 0, 0, (x % 3) == 0, x - 4095);
        end
        idle(4);

        // R5: retune in the same cycle as a sample
        cur_req = "R5";
        for (int j = 0; j < 5; j++) drive(0, 0, 0, 1, 3000);
        drive(1, 46341, -46341, 1, 5000);
        for (int j = 0; j < 6; j++) drive(0, 0, 0, 1, 5000);
        idle(4);

        // R6: step above unit magnitude across several correction intervals
        cur_req = "R6";
        drive(1, 66000, -3000, 0, 0);
        for (int j = 0; j < 70; j++) drive(0, 0, 0, 1, 6000 - 50 * j);
        idle(4);

        // R7: oversized step drives the phasor into saturation
        cur_req = "R7";
        drive(1, 120000, 0, 0, 0);
        for (int j = 0; j < 40; j++) drive(0, 0, 0, 1, 8191);
        idle(4);

        // R2: every accepted sample produced its pulse
        cur_req = "R2";
        idle(3);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d pending results expected 0", expq.size());
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule